// File: doc/BRIEF.md
# Period-Four Pattern Branch Predictor

This block predicts a single conditional branch whose outcomes follow a four-long cycle: two taken outcomes, then two not-taken outcomes. It also handles the inverted cycle (two not-taken, then two taken). Each time the pipeline reports a conditional branch, it raises a strobe and presents the branch's resolved outcome. The predictor uses that outcome in the same cycle to update its internal position. Its prediction for the next branch appears on the following cycle.

The state is a two-bit phase counter and a polarity bit. Together they select one slot of the base cycle, or that slot inverted. After a correct guess the phase steps forward by one. After a wrong guess the predictor rebuilds its phase and polarity from the last two outcomes it saw. Any two consecutive outcomes of either cycle fix the next outcome, so the predictor is back in lock within two branches. This holds from reset and after any jump or inversion of the pattern.

Top module: `pp_pattern_predictor`

## Requirements
- R1: After reset the prediction is 1 (taken) before any branch is reported.
- R2: The prediction output is 1 for taken and 0 for not taken. The outcome input uses the same encoding.
- R3: On cycles where the strobe is low, the prediction and all internal state stay unchanged, whatever the outcome input carries.
- R4: When outcomes follow the cycle taken, taken, not-taken, not-taken, entered at any of its four slots, no branch after the second one reported since reset is mispredicted.
- R5: When outcomes follow the inverted cycle not-taken, not-taken, taken, taken, no branch after the second one is mispredicted either.
- R6: After a mispredicted branch, the next prediction is the inverse of the outcome reported just before the mispredicted one. Before the first branch after reset, that earlier outcome counts as not-taken.
- R7: After reset, or after the outcome stream switches to a different slot or polarity of the cycle, at most two branches are mispredicted. All later branches are predicted correctly.
- R8: After a correctly predicted branch, the phase advances by one modulo four and the polarity is kept.
- R9: The outcome presented with a strobe is used in that same cycle, and the resulting prediction is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| branch_valid_i | input | 1 | Strobe: a conditional branch is being reported this cycle |
| taken_i | input | 1 | Resolved outcome of the reported branch, 1 = taken |
| predict_taken_o | output | 1 | Prediction for the next branch, 1 = taken |

## Verification
The base cycle is applied from reset at each of its four entry slots. This shows whether realignment handles offsets of one, two and three positions, and not only the one slot that reset already matches. The inverted cycle is applied from reset and also as a mid-run switch away from a locked base cycle, which separates the polarity flip from a plain phase shift and bounds the relearning cost. Idle cycles with a toggling outcome input show that only strobed outcomes move the state. A vector table with a known misprediction pair pins down the exact prediction sequence, cycle by cycle.

// File: rtl/pp_pred_pkg.sv
package pp_pred_pkg;
  localparam int PERIOD  = 4;
  localparam int PHASE_W = $clog2(PERIOD);

  typedef logic [PHASE_W-1:0] phase_t;

  typedef struct packed {
    phase_t phase;
    logic   pol;
  } align_t;

  // Base cycle slot value: slots 0,1 taken, slots 2,3 not taken.
  function automatic logic base_bit(phase_t p);
    return ~p[PHASE_W-1];
  endfunction

  // Prediction from phase and polarity.
  function automatic logic predict(align_t s);
    return base_bit(s.phase) ^ s.pol;
  endfunction

  // Slot of the base cycle at which outcome 'cur' follows outcome 'prev'.
  function automatic phase_t pair_slot(logic prev, logic cur);
    return {~cur, prev ^ ~cur};
  endfunction

  // New alignment after a miss: the next effective slot must be pair_slot+1.
  // Effective slot = phase + 2*pol. Keep the counter stepping when the
  // offset is even and absorb it in the polarity; otherwise reload the phase.
  function automatic align_t realign(align_t s, logic prev, logic cur);
    align_t r;
    phase_t slot;
    phase_t diff;
    slot = pair_slot(prev, cur);
    diff = slot - s.phase;
    if (!diff[0]) begin
      r.phase = s.phase + phase_t'(1);
      r.pol   = diff[1];
    end else begin
      r.phase = slot + phase_t'(1);
      r.pol   = 1'b0;
    end
    return r;
  endfunction
endpackage

// File: rtl/pp_outcome_hist.sv
module pp_outcome_hist (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic outcome_i,
  output logic last_o
);
  // Reset value 0 (not taken) matches the slot before phase 0.
  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     last_q <= 1'b0;
    else if (stb_i) last_q <= outcome_i;
  end

  assign last_o = last_q;

  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(last_o));
endmodule

// File: rtl/pp_align_state.sv
module pp_align_state
  import pp_pred_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stb_i,
  input  logic   miss_i,
  input  logic   prev_i,
  input  logic   cur_i,
  output align_t state_o
);
  align_t state_q;
  align_t state_d;
  align_t fixed;

  always_comb begin
    fixed   = realign(state_q, prev_i, cur_i);
    state_d = state_q;
    if (stb_i) begin
      if (miss_i) state_d = fixed;
      else        state_d = '{phase: state_q.phase + phase_t'(1), pol: state_q.pol};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= '{phase: '0, pol: 1'b0};
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_i |=> $stable(state_o));

  assert_hit_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb_i && !miss_i |=> (state_o.phase == phase_t'($past(state_o.phase) + 1))
                         && (state_o.pol == $past(state_o.pol)));
endmodule

// File: rtl/pp_pattern_predictor.sv
module pp_pattern_predictor
  import pp_pred_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic branch_valid_i,
  input  logic taken_i,
  output logic predict_taken_o
);
  align_t state;
  logic   last_outcome;
  logic   pred;
  logic   miss_evt;

  assign pred     = predict(state);
  assign miss_evt = branch_valid_i && (pred != taken_i);

  pp_outcome_hist u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_i     (branch_valid_i),
    .outcome_i (taken_i),
    .last_o    (last_outcome)
  );

  pp_align_state u_align (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb_i   (branch_valid_i),
    .miss_i  (miss_evt),
    .prev_i  (last_outcome),
    .cur_i   (taken_i),
    .state_o (state)
  );

  assign predict_taken_o = pred;

  assert_reset_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> predict_taken_o);

  assert_miss_realign_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> predict_taken_o == ~$past(last_outcome));

  assert_idle_pred_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !branch_valid_i |=> $stable(predict_taken_o));
endmodule

// File: tb/tb_pp_pattern_predictor.sv
module tb_pp_pattern_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  // Entry: {strobe, outcome, expected prediction before the edge}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b111, 3'b111, 3'b100, 3'b100,
    3'b111, 3'b111, 3'b100, 3'b100,
    3'b101, 3'b101, 3'b111, 3'b111,
    3'b100, 3'b100, 3'b011, 3'b111
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic outc = 1'b0;
  logic pred;

  int checks = 0;
  int failures = 0;
  logic m_new = 1'b0;
  logic m_old = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_pattern_predictor dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .branch_valid_i  (stb),
    .taken_i         (outc),
    .predict_taken_o (pred)
  );

  task automatic check(input logic ok, input string req, input logic act, input logic exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Independent model: next outcome of either cycle is the inverse of the
  // outcome two branches back; before reset both virtual outcomes are 0.
  function automatic logic model_pred();
    return ~m_old;
  endfunction

  function automatic logic pat(int k, logic inv);
    return ((k % 4) < 2) ^ inv;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stb = 1'b0; outc = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_new = 1'b0; m_old = 1'b0;
    #1;
  endtask

  task automatic branch(input logic o, input string req, output logic missed);
    @(negedge clk);
    stb = 1'b1; outc = o;
    #1;
    check(pred == model_pred(), req, pred, model_pred());
    missed = (pred != o);
    @(posedge clk);
    #1;
    stb = 1'b0;
    m_old = m_new; m_new = o;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ms;
    int late;
    int early;
    logic held;

    do_reset();
    // R1: reset state
    check(pred == 1'b1, "R1", pred, 1'b1);

    // Vector table walk (R2, R6, R9, R3)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      stb = VEC[i][2]; outc = VEC[i][1];
      #1;
      check(pred == VEC[i][0], "R2_R6_R9 table", pred, VEC[i][0]);
      @(posedge clk);
      #1;
      if (!VEC[i][2])
        check(pred == VEC[i][0], "R3 table idle", pred, VEC[i][0]);
      stb = 1'b0;
    end

    // Inverted cycle from reset (R5, R7)
    do_reset();
    early = 0; late = 0;
    for (int k = 0; k < 24; k++) begin
      branch(pat(k, 1'b1), "R5 inverted", ms);
      if (ms) begin
        if (k < 2) early++; else late++;
      end
    end
    check(late == 0, "R5 no late miss", late != 0, 1'b0);
    check(early <= 2, "R7 warmup bound inverted", early > 2, 1'b0);

    // Base cycle entered at each slot (R4, R7)
    for (int off = 0; off < 4; off++) begin
      do_reset();
      late = 0;
      for (int k = 0; k < 20; k++) begin
        branch(pat(k + off, 1'b0), "R4 base", ms);
        if (ms && k >= 2) late++;
      end
      check(late == 0, "R4 base offset no late miss", late != 0, 1'b0);
    end

    // Locked base then switch to inverted mid-run (R7, R8)
    do_reset();
    late = 0;
    for (int k = 0; k < 8; k++) begin
      branch(pat(k, 1'b0), "R8 locked", ms);
      if (ms) late++;
    end
    check(late == 0, "R8 locked base no miss", late != 0, 1'b0);
    early = 0; late = 0;
    for (int k = 0; k < 16; k++) begin
      branch(pat(k, 1'b1), "R7 switch", ms);
      if (ms) begin
        if (k < 2) early++; else late++;
      end
    end
    check(early <= 2 && late == 0, "R7 switch relock", late != 0, 1'b0);

    // Idle cycles with toggling outcome (R3)
    held = pred;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      stb = 1'b0; outc = k[0];
      @(posedge clk);
      #1;
      check(pred == held, "R3 idle hold", pred, held);
    end
    branch(pat(16, 1'b1), "R3 after idle", ms);
    check(!ms, "R3 idle kept lock", ms, 1'b0);

    // Reset mid-run returns to taken (R1)
    do_reset();
    check(pred == 1'b1, "R1 mid-run reset", pred, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule